// File: doc/BRIEF.md
# Audio Sample FIFO with Watermark Flags and Error Halt

This block is an eight-word, 32-bit sample buffer placed between a bus-side register port and a serial audio shifter. A parameter fixes its orientation at build time. In transmit orientation the bus side fills the buffer and the serial side drains it. In receive orientation the serial side fills it and the bus side drains it. The producer port and the consumer port are the same in both orientations. The orientation only decides which of them is the serial side.

Software sets a fill threshold. The block derives two registered flags from it. A service-request flag asks for more data (transmit) or for data to be taken away (receive). A warning flag marks the dangerous end of the buffer: empty for transmit, full for receive. A serial strobe that finds no word to send, or no room to store one, latches an error flag. Unless the continue option is set, the error also freezes the serial side until software writes one to the error clear input. A separate pulse empties the buffer and drops the error in one step.

Top module: `sample_fifo`

## Requirements
- R1: The reset state has a fill level of 0 and the error flag low. In transmit orientation request and warning are both 1. In receive orientation both are 0.
- R2: Words leave the buffer in the order they entered. The popped word appears on cons_data on the clock edge that accepts the pop.
- R3: fill_level counts the stored words, up to 8. A push into a full buffer with no pop in the same cycle is discarded and leaves fill_level unchanged. A push and a pop in the same cycle leave the level unchanged.
- R4: In transmit orientation req_flag is 1 exactly when fill_level is at or below the threshold. A threshold above 8 counts as 8. The flag follows the level one clock later.
- R5: In receive orientation req_flag is 1 exactly when fill_level is strictly above the threshold. The flag follows the level one clock later.
- R6: warn_flag is 1 when the buffer is empty in transmit orientation, and when it holds 8 words in receive orientation. The flag follows the level one clock later.
- R7: In transmit orientation, a serial pop from an empty buffer sets err_flag on that edge and loads zero into cons_data.
- R8: In receive orientation, a serial push into a full buffer sets err_flag on that edge and discards the word.
- R9: While err_flag is 1 and cfg_continue is 0, ser_halt is 1 and serial-side strobes change neither the fill level nor the data.
- R10: With cfg_continue at 1, serial transfers keep working while err_flag stays set.
- R11: A one on err_clr clears err_flag on the next edge. A new error in that same cycle wins, and err_flag stays 1.
- R12: A one on fifo_rst empties the buffer and clears err_flag on the next edge. Any transfer in that cycle is ignored.
- R13: In receive orientation, a bus read from an empty buffer returns zero and does not raise the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_watermark | input | 4 | Fill threshold, 0 to 8 |
| cfg_continue | input | 1 | 1 keeps the serial side running after an error |
| fifo_rst | input | 1 | Write-one pulse: empty the buffer and clear the error |
| err_clr | input | 1 | Write-one pulse: clear the latched error |
| prod_en | input | 1 | Push strobe (bus write for transmit, serial strobe for receive) |
| prod_data | input | 32 | Word to push |
| cons_en | input | 1 | Pop strobe (serial strobe for transmit, bus read for receive) |
| cons_data | output | 32 | Registered popped word |
| fill_level | output | 4 | Number of stored words |
| req_flag | output | 1 | Registered threshold request |
| warn_flag | output | 1 | Registered empty (transmit) or full (receive) warning |
| err_flag | output | 1 | Latched underrun or overrun |
| ser_halt | output | 1 | Serial side frozen by an unserviced error |

## Verification
The hardest state to reach from the ports is a serial strobe that arrives while the error is latched and the buffer holds words. To show the freeze, the halt has to block a transfer that would otherwise succeed.

The stimulus gets there in a fixed order:
- drain the transmit buffer to empty and strobe once to force an underrun;
- refill it from the bus side, which stays live during the halt;
- strobe the serial side and check that the level does not move.

The same path with the continue option set shows transfers going on under a standing error. A clear pulse that coincides with a fresh underrun checks the priority of setting over clearing.

// File: rtl/sample_fifo_pkg.sv
package sample_fifo_pkg;
  typedef enum logic {
    ORIENT_RX = 1'b0,
    ORIENT_TX = 1'b1
  } orient_e;
endpackage

// File: rtl/sample_fifo_store.sv
module sample_fifo_store #(
  parameter int DEPTH = 8,
  parameter int DW    = 32,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push_en,
  input  logic [DW-1:0] push_data,
  input  logic          pop_en,
  output logic [DW-1:0] pop_data,
  output logic [CW-1:0] count,
  output logic          push_drop,
  output logic          pop_miss
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count_q;
  logic          full, empty, push_ok, pop_ok;

  function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full      = (count_q == CW'(DEPTH));
  assign empty     = (count_q == '0);
  assign pop_ok    = pop_en & ~flush & ~empty;
  assign push_ok   = push_en & ~flush & (~full | pop_ok);
  assign push_drop = push_en & ~flush & ~push_ok;
  assign pop_miss  = pop_en & ~flush & ~pop_ok;
  assign count     = count_q;

  // storage array, no reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst || flush)  pop_data <= '0;
    else if (pop_en)   pop_data <= pop_ok ? mem[rd_ptr] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else begin
      if (push_ok) wr_ptr <= step_ptr(wr_ptr);
      if (pop_ok)  rd_ptr <= step_ptr(rd_ptr);
      if (push_ok && !pop_ok)      count_q <= count_q + CW'(1);
      else if (pop_ok && !push_ok) count_q <= count_q - CW'(1);
    end
  end

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
    count_q <= CW'(DEPTH)); // R3
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (full && push_en && !pop_en && !flush) |=> $stable(count_q)); // R3
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush |=> (count_q == '0)); // R12
endmodule

// File: rtl/sample_fifo_flags.sv
module sample_fifo_flags
  import sample_fifo_pkg::*;
#(
  parameter int      DEPTH  = 8,
  parameter orient_e ORIENT = ORIENT_TX,
  localparam int     CW     = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] watermark,
  output logic          req_q,
  output logic          warn_q
);
  localparam logic IS_TX = (ORIENT == ORIENT_TX);

  logic [CW-1:0] wm_eff;
  logic          req_nx, warn_nx;

  assign wm_eff = (watermark > CW'(DEPTH)) ? CW'(DEPTH) : watermark;

  generate
    if (IS_TX) begin : g_tx
      assign req_nx  = (count <= wm_eff);
      assign warn_nx = (count == '0);
      AST_WARN_TX_LAG: assert property (@(posedge clk) disable iff (rst)
        ($past(count) == '0) == warn_q); // R6
    end else begin : g_rx
      assign req_nx  = (count > wm_eff);
      assign warn_nx = (count == CW'(DEPTH));
      AST_WARN_RX_LAG: assert property (@(posedge clk) disable iff (rst)
        ($past(count) == CW'(DEPTH)) == warn_q); // R6
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= IS_TX;
      warn_q <= IS_TX;
    end else begin
      req_q  <= req_nx;
      warn_q <= warn_nx;
    end
  end
endmodule

// File: rtl/sample_fifo_err.sv
module sample_fifo_err (
  input  logic clk,
  input  logic rst,
  input  logic flush,
  input  logic clr,
  input  logic fault,
  input  logic cont,
  output logic err_q,
  output logic halt
);
  always_ff @(posedge clk) begin
    if (rst || flush)  err_q <= 1'b0;
    else if (fault)    err_q <= 1'b1;
    else if (clr)      err_q <= 1'b0;
  end

  assign halt = err_q & ~cont;

  AST_ERR_LATCH: assert property (@(posedge clk) disable iff (rst)
    fault |=> err_q); // R7
  AST_CLR_WORKS: assert property (@(posedge clk) disable iff (rst)
    (clr && !fault) |=> !err_q); // R11
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
    flush |=> !err_q); // R12
endmodule

// File: rtl/sample_fifo.sv
module sample_fifo
  import sample_fifo_pkg::*;
#(
  parameter int      DEPTH  = 8,
  parameter int      DW     = 32,
  parameter orient_e ORIENT = ORIENT_TX,
  localparam int     CW     = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cfg_watermark,
  input  logic          cfg_continue,
  input  logic          fifo_rst,
  input  logic          err_clr,
  input  logic          prod_en,
  input  logic [DW-1:0] prod_data,
  input  logic          cons_en,
  output logic [DW-1:0] cons_data,
  output logic [CW-1:0] fill_level,
  output logic          req_flag,
  output logic          warn_flag,
  output logic          err_flag,
  output logic          ser_halt
);
  localparam logic IS_TX = (ORIENT == ORIENT_TX);

  logic push_en, pop_en, push_drop, pop_miss, fault, halt;

  // the serial side is the consumer for transmit, the producer for receive
  assign push_en = IS_TX ? prod_en : (prod_en & ~halt);
  assign pop_en  = IS_TX ? (cons_en & ~halt) : cons_en;
  assign fault   = IS_TX ? pop_miss : push_drop;

  sample_fifo_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk       (clk),
    .rst       (rst),
    .flush     (fifo_rst),
    .push_en   (push_en),
    .push_data (prod_data),
    .pop_en    (pop_en),
    .pop_data  (cons_data),
    .count     (fill_level),
    .push_drop (push_drop),
    .pop_miss  (pop_miss)
  );

  sample_fifo_flags #(.DEPTH(DEPTH), .ORIENT(ORIENT)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .count     (fill_level),
    .watermark (cfg_watermark),
    .req_q     (req_flag),
    .warn_q    (warn_flag)
  );

  sample_fifo_err u_err (
    .clk   (clk),
    .rst   (rst),
    .flush (fifo_rst),
    .clr   (err_clr),
    .fault (fault),
    .cont  (cfg_continue),
    .err_q (err_flag),
    .halt  (halt)
  );

  assign ser_halt = halt;

  generate
    if (IS_TX) begin : g_tx_chk
      AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (halt && cons_en && !prod_en && !fifo_rst) |=> $stable(fill_level)); // R9
    end else begin : g_rx_chk
      AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (halt && prod_en && !cons_en && !fifo_rst) |=> $stable(fill_level)); // R9
    end
  endgenerate
endmodule

// File: tb/sample_fifo_tb.sv
`timescale 1ns/1ps
module sample_fifo_tb;
  import sample_fifo_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  int nchk  = 0;
  int nfail = 0;
  bit done  = 1'b0;

  // transmit instance
  logic [3:0]  t_wm = 4'd0;
  logic        t_cont = 1'b0, t_frst = 1'b0, t_clr = 1'b0;
  logic        t_pen = 1'b0, t_cen = 1'b0;
  logic [31:0] t_pdata = '0, t_cdata;
  logic [3:0]  t_fill;
  logic        t_req, t_warn, t_err, t_halt;

  sample_fifo #(.ORIENT(ORIENT_TX)) u_dut (
    .clk(clk), .rst(rst), .cfg_watermark(t_wm), .cfg_continue(t_cont),
    .fifo_rst(t_frst), .err_clr(t_clr), .prod_en(t_pen), .prod_data(t_pdata),
    .cons_en(t_cen), .cons_data(t_cdata), .fill_level(t_fill),
    .req_flag(t_req), .warn_flag(t_warn), .err_flag(t_err), .ser_halt(t_halt));

  // receive instance
  logic [3:0]  r_wm = 4'd3;
  logic        r_cont = 1'b0, r_frst = 1'b0, r_clr = 1'b0;
  logic        r_pen = 1'b0, r_cen = 1'b0;
  logic [31:0] r_pdata = '0, r_cdata;
  logic [3:0]  r_fill;
  logic        r_req, r_warn, r_err, r_halt;

  sample_fifo #(.ORIENT(ORIENT_RX)) u_rx (
    .clk(clk), .rst(rst), .cfg_watermark(r_wm), .cfg_continue(r_cont),
    .fifo_rst(r_frst), .err_clr(r_clr), .prod_en(r_pen), .prod_data(r_pdata),
    .cons_en(r_cen), .cons_data(r_cdata), .fill_level(r_fill),
    .req_flag(r_req), .warn_flag(r_warn), .err_flag(r_err), .ser_halt(r_halt));

  // {prod_en, cons_en, watermark[3:0], fill[3:0], req, warn}
  localparam logic [11:0] TX_VEC [18] = '{
    {1'b1, 1'b0, 4'd2,  4'd1, 1'b1, 1'b0},
    {1'b1, 1'b0, 4'd2,  4'd2, 1'b1, 1'b0},
    {1'b1, 1'b0, 4'd2,  4'd3, 1'b0, 1'b0},
    {1'b1, 1'b0, 4'd4,  4'd4, 1'b1, 1'b0},
    {1'b1, 1'b1, 4'd4,  4'd4, 1'b1, 1'b0},
    {1'b1, 1'b0, 4'd4,  4'd5, 1'b0, 1'b0},
    {1'b1, 1'b0, 4'd4,  4'd6, 1'b0, 1'b0},
    {1'b1, 1'b0, 4'd8,  4'd7, 1'b1, 1'b0},
    {1'b1, 1'b0, 4'd8,  4'd8, 1'b1, 1'b0},
    {1'b1, 1'b0, 4'd7,  4'd8, 1'b0, 1'b0},
    {1'b0, 1'b1, 4'd15, 4'd7, 1'b1, 1'b0},
    {1'b0, 1'b1, 4'd0,  4'd6, 1'b0, 1'b0},
    {1'b0, 1'b1, 4'd0,  4'd5, 1'b0, 1'b0},
    {1'b0, 1'b1, 4'd0,  4'd4, 1'b0, 1'b0},
    {1'b0, 1'b1, 4'd0,  4'd3, 1'b0, 1'b0},
    {1'b0, 1'b1, 4'd0,  4'd2, 1'b0, 1'b0},
    {1'b0, 1'b1, 4'd0,  4'd1, 1'b0, 1'b0},
    {1'b0, 1'b1, 4'd0,  4'd0, 1'b1, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] txword(input int k);
    return 32'hC0DE_0000 ^ (32'(k) * 32'h0101_0101);
  endfunction

  // one transmit cycle: drive at a falling edge, release at the next
  task automatic tx_cycle(input logic pe, input logic ce, input logic [31:0] d);
    t_pen = pe; t_cen = ce; t_pdata = d;
    @(negedge clk);
    t_pen = 1'b0; t_cen = 1'b0;
  endtask

  task automatic rx_push(input logic [31:0] d);
    r_pen = 1'b1; r_pdata = d;
    @(negedge clk);
    r_pen = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] q [$];
    int          wcount;
    int          mf;
    logic [31:0] exp_d;
    wcount = 0;
    mf = 0;

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 tx fill", 32'(t_fill), 32'd0);
    chk("R1 tx req",  32'(t_req),  32'd1);
    chk("R1 tx warn", 32'(t_warn), 32'd1);
    chk("R1 tx err",  32'(t_err),  32'd0);
    chk("R1 rx req",  32'(r_req),  32'd0);
    chk("R1 rx warn", 32'(r_warn), 32'd0);

    // table walk on the transmit instance
    for (int i = 0; i < 18; i++) begin
      logic pe, ce, pop_ok, push_ok;
      pe = TX_VEC[i][11];
      ce = TX_VEC[i][10];
      t_wm = TX_VEC[i][9:6];
      pop_ok  = ce && (mf > 0);
      push_ok = pe && ((mf < 8) || pop_ok);
      if (pop_ok) exp_d = q.pop_front();
      if (push_ok) q.push_back(txword(wcount));
      tx_cycle(pe, ce, txword(wcount));
      if (pe) wcount++;
      mf = mf + (push_ok ? 1 : 0) - (pop_ok ? 1 : 0);
      chk("R3 fill", 32'(t_fill), 32'(TX_VEC[i][5:2]));
      if (pop_ok) chk("R2 order", t_cdata, exp_d);
      @(negedge clk);
      chk("R4 req",  32'(t_req),  32'(TX_VEC[i][1]));
      chk("R6 warn", 32'(t_warn), 32'(TX_VEC[i][0]));
    end

    // R7 underrun on empty buffer
    t_cont = 1'b0;
    tx_cycle(1'b0, 1'b1, '0);
    chk("R7 err set",   32'(t_err),  32'd1);
    chk("R7 zero data", t_cdata,     32'd0);
    chk("R9 halt",      32'(t_halt), 32'd1);

    // R9 refill from the bus, serial strobe must be frozen
    tx_cycle(1'b1, 1'b0, 32'h1111_0001);
    tx_cycle(1'b1, 1'b0, 32'h1111_0002);
    chk("R9 bus fill", 32'(t_fill), 32'd2);
    tx_cycle(1'b0, 1'b1, '0);
    chk("R9 frozen fill", 32'(t_fill), 32'd2);
    chk("R9 frozen data", t_cdata, 32'd0);

    // R11 clear resumes the flow
    t_clr = 1'b1; @(negedge clk); t_clr = 1'b0;
    chk("R11 err cleared", 32'(t_err),  32'd0);
    chk("R11 halt gone",   32'(t_halt), 32'd0);
    tx_cycle(1'b0, 1'b1, '0);
    chk("R11 pop fill", 32'(t_fill), 32'd1);
    chk("R2 first word", t_cdata, 32'h1111_0001);

    // R10 continue mode
    t_cont = 1'b1;
    tx_cycle(1'b0, 1'b1, '0);
    chk("R2 second word", t_cdata, 32'h1111_0002);
    tx_cycle(1'b0, 1'b1, '0);
    chk("R10 err set", 32'(t_err),  32'd1);
    chk("R10 no halt", 32'(t_halt), 32'd0);
    tx_cycle(1'b1, 1'b0, 32'h2222_0003);
    tx_cycle(1'b0, 1'b1, '0);
    chk("R10 pop fill", 32'(t_fill), 32'd0);
    chk("R10 pop data", t_cdata, 32'h2222_0003);
    chk("R10 err kept", 32'(t_err), 32'd1);

    // R11 clear colliding with a fresh underrun
    t_clr = 1'b1;
    tx_cycle(1'b0, 1'b1, '0);
    t_clr = 1'b0;
    chk("R11 set wins", 32'(t_err), 32'd1);

    // R12 pointer reset
    tx_cycle(1'b1, 1'b0, 32'h3333_0001);
    tx_cycle(1'b1, 1'b0, 32'h3333_0002);
    tx_cycle(1'b1, 1'b0, 32'h3333_0003);
    t_wm = 4'd1;
    @(negedge clk);
    chk("R4 req above wm", 32'(t_req), 32'd0);
    t_frst = 1'b1; @(negedge clk); t_frst = 1'b0;
    chk("R12 fill", 32'(t_fill), 32'd0);
    chk("R12 err",  32'(t_err),  32'd0);
    @(negedge clk);
    chk("R12 warn", 32'(t_warn), 32'd1);
    chk("R12 req",  32'(t_req),  32'd1);

    // receive orientation, threshold 3
    r_cont = 1'b0;
    for (int k = 0; k < 3; k++) rx_push(32'h5A00_0000 + 32'(k));
    @(negedge clk);
    chk("R5 req at wm", 32'(r_req), 32'd0);
    rx_push(32'h5A00_0003);
    @(negedge clk);
    chk("R5 req above wm", 32'(r_req), 32'd1);
    chk("R6 rx not full",  32'(r_warn), 32'd0);
    for (int k = 4; k < 8; k++) rx_push(32'h5A00_0000 + 32'(k));
    @(negedge clk);
    chk("R6 rx full warn", 32'(r_warn), 32'd1);
    rx_push(32'hDEAD_BEEF);
    chk("R8 overrun err", 32'(r_err),  32'd1);
    chk("R8 fill held",   32'(r_fill), 32'd8);
    chk("R9 rx halt",     32'(r_halt), 32'd1);
    for (int k = 0; k < 8; k++) begin
      r_cen = 1'b1; @(negedge clk); r_cen = 1'b0;
      chk("R2 rx order", r_cdata, 32'h5A00_0000 + 32'(k));
    end
    chk("R8 word dropped", 32'(r_fill), 32'd0);
    r_cen = 1'b1; @(negedge clk); r_cen = 1'b0;
    chk("R13 empty read", r_cdata, 32'd0);
    chk("R13 fill",       32'(r_fill), 32'd0);
    @(negedge clk);
    chk("R5 rx req low",  32'(r_req),  32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule